// File: doc/BRIEF.md
# Masked wavefront SIMD execution unit

This unit executes one vector integer instruction for a 64-lane wavefront on a 16-lane physical datapath. An accepted instruction is split into four batches of 16 lanes. The batches enter a four-stage pipeline on consecutive clocks: sequence, register read, lane ALU, writeback. Each wave register holds 64 lanes of 32 bits. It is stored as four rows of 16 lanes in an on-chip register file with per-lane write enables.

A 64-bit execution mask comes with every instruction. Its 16-bit slice for a batch decides which lanes of that batch write back. The lanes of a partly filled wave and the lanes that failed a branch are masked in the same way. A store instruction produces per-batch memory requests instead of register writes. Masked lanes take part in no request, and a batch whose slice is empty produces no request at all.

A new instruction for the same wave can follow every fourth clock with no stall. A strobe that arrives sooner is dropped and flagged.

Top module: `wave_simd_unit`

## Requirements
- R1: After synchronous reset, wr_valid, st_valid, done and err are 0.
- R2: For an instruction accepted at clock edge E, batch k (lanes 16k to 16k+15) appears on the outputs in the cycle that follows edge E+3+k, with out_batch = k, for k = 0 to 3.
- R3: Opcode encoding on in_op is 0 add, 1 subtract (a minus b), 2 bitwise and, 3 bitwise or, 4 signed minimum, 5 signed maximum, 6 seed (imm plus the lane index 0..63), 7 store. Arithmetic wraps modulo 2^32.
- R4: Each of the 8 wave registers holds 64 lanes of 32 bits, and the values written persist until the same lane of that register is written again.
- R5: For an ALU op (opcodes 0 to 6), wr_lane_en for batch k equals in_exec[16k+15:16k]. Lanes whose mask bit is 0 keep their previous register contents. Lane j of a batch sits at wr_data[32j+31:32j].
- R6: A batch whose mask slice is all zero raises neither wr_valid nor st_valid.
- R7: A store (opcode 7) writes no register. For each batch with a non-zero slice it raises st_valid, with st_lane_en equal to the slice and st_data holding the src_a register lanes of that batch in the same lane positions.
- R8: done is high for exactly one cycle per accepted instruction, in the cycle where batch 3 appears (out_batch = 3). This holds even when the whole mask is zero.
- R9: An in_valid seen exactly 4 edges after an accepted instruction is accepted. It reads the results of that previous instruction without a stall.
- R10: An in_valid seen 1 to 3 edges after an accepted instruction is ignored: it writes no register and starts no batch. err is high in the cycle after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction strobe |
| in_op | input | 3 | Opcode |
| in_dst | input | 3 | Destination register index |
| in_src_a | input | 3 | First source register index |
| in_src_b | input | 3 | Second source register index |
| in_imm | input | 32 | Immediate for the seed op |
| in_exec | input | 64 | Per-lane execution mask |
| out_batch | output | 2 | Batch index of the current output cycle |
| wr_valid | output | 1 | Register write happened for this batch |
| wr_reg | output | 3 | Register written |
| wr_lane_en | output | 16 | Lanes written in this batch |
| wr_data | output | 512 | Result data of the 16 lanes |
| st_valid | output | 1 | Store request for this batch |
| st_lane_en | output | 16 | Lanes taking part in the store request |
| st_data | output | 512 | Store data of the 16 lanes |
| done | output | 1 | Last batch of an instruction is out |
| err | output | 1 | A strobe was dropped for arriving early |

## Verification
The done pulse of one instruction and the reject flag of an early strobe can land in the same cycle. This happens when a second instruction is issued on the four-clock cadence and a stray strobe then arrives two edges later, while the second one is still being sequenced. The bench drives exactly that pattern. It expects batch 3 of the first instruction, done and err all in one cycle. It then expects the four batches of the second instruction to carry correct dependent results. A later store of the stray strobe's destination register must show that register unchanged.

// File: rtl/wsu_pkg.sv
package wsu_pkg;
  typedef enum logic [2:0] {
    OP_ADD   = 3'd0,
    OP_SUB   = 3'd1,
    OP_AND   = 3'd2,
    OP_OR    = 3'd3,
    OP_MIN   = 3'd4,
    OP_MAX   = 3'd5,
    OP_SEED  = 3'd6,
    OP_STORE = 3'd7
  } op_e;
endpackage

// File: rtl/wsu_sequencer.sv
module wsu_sequencer
  import wsu_pkg::*;
#(
  parameter int WAVE_LANES = 64,
  parameter int SIMD_LANES = 16,
  parameter int REG_AW     = 3,
  parameter int DATA_W     = 32,
  localparam int NBATCH    = WAVE_LANES / SIMD_LANES,
  localparam int BW        = (NBATCH > 1) ? $clog2(NBATCH) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_valid,
  input  op_e                   in_op,
  input  logic [REG_AW-1:0]     in_dst,
  input  logic [REG_AW-1:0]     in_src_a,
  input  logic [REG_AW-1:0]     in_src_b,
  input  logic [DATA_W-1:0]     in_imm,
  input  logic [WAVE_LANES-1:0] in_exec,
  output logic                  seq_vld,
  output logic [BW-1:0]         seq_batch,
  output logic                  seq_last,
  output op_e                   seq_op,
  output logic [REG_AW-1:0]     seq_dst,
  output logic [REG_AW-1:0]     seq_src_a,
  output logic [REG_AW-1:0]     seq_src_b,
  output logic [DATA_W-1:0]     seq_imm,
  output logic [SIMD_LANES-1:0] seq_mask,
  output logic                  err_o
);
  logic                  active_q;
  logic [BW-1:0]         cnt_q;
  logic [WAVE_LANES-1:0] mask_q;
  logic                  ready;
  logic                  accept;

  assign seq_last = (cnt_q == BW'(NBATCH - 1));
  assign ready    = !active_q || seq_last;
  assign accept   = in_valid && ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      err_o    <= 1'b0;
    end else begin
      err_o <= in_valid && !ready;
      if (accept) begin
        active_q <= 1'b1;
        cnt_q    <= '0;
      end else if (active_q) begin
        if (seq_last) active_q <= 1'b0;
        else          cnt_q    <= cnt_q + BW'(1);
      end
    end
  end

  // instruction fields need no reset: they are qualified by active_q
  always_ff @(posedge clk) begin
    if (accept) begin
      seq_op    <= in_op;
      seq_dst   <= in_dst;
      seq_src_a <= in_src_a;
      seq_src_b <= in_src_b;
      seq_imm   <= in_imm;
      mask_q    <= in_exec;
    end
  end

  assign seq_vld   = active_q;
  assign seq_batch = cnt_q;
  assign seq_mask  = mask_q[cnt_q * SIMD_LANES +: SIMD_LANES];

  // R9
  cadence_busy_chk: assert property (@(posedge clk) disable iff (rst)
    accept |=> (seq_vld && seq_batch == '0));

  // R10
  err_inflight_chk: assert property (@(posedge clk) disable iff (rst)
    err_o |-> seq_vld);

  // R2
  batch_step_chk: assert property (@(posedge clk) disable iff (rst)
    (seq_vld && !seq_last) |=> (seq_vld && seq_batch == $past(seq_batch) + BW'(1)));
endmodule

// File: rtl/wsu_regfile.sv
module wsu_regfile #(
  parameter int ADDR_W     = 5,
  parameter int SIMD_LANES = 16,
  parameter int DATA_W     = 32,
  localparam int DEPTH     = 2 ** ADDR_W,
  localparam int ROW_W     = SIMD_LANES * DATA_W
) (
  input  logic                  clk,
  input  logic [SIMD_LANES-1:0] we,
  input  logic [ADDR_W-1:0]     waddr,
  input  logic [ROW_W-1:0]      wdata,
  input  logic [ADDR_W-1:0]     raddr_a,
  input  logic [ADDR_W-1:0]     raddr_b,
  output logic [ROW_W-1:0]      rdata_a,
  output logic [ROW_W-1:0]      rdata_b
);
  logic [1:0][ADDR_W-1:0] raddr;
  logic [1:0][ROW_W-1:0]  rdata;

  assign raddr   = {raddr_b, raddr_a};
  assign rdata_a = rdata[0];
  assign rdata_b = rdata[1];

  // one copy per read port, both written identically; lane enables map to RAM byte-enables
  for (genvar p = 0; p < 2; p++) begin : g_bank
    logic [ROW_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      for (int l = 0; l < SIMD_LANES; l++) begin
        if (we[l]) mem[waddr][l*DATA_W +: DATA_W] <= wdata[l*DATA_W +: DATA_W];
      end
      rdata[p] <= mem[raddr[p]];
    end
  end
endmodule

// File: rtl/wsu_lane_alu.sv
module wsu_lane_alu
  import wsu_pkg::*;
#(
  parameter int SIMD_LANES = 16,
  parameter int DATA_W     = 32,
  parameter int BW         = 2,
  localparam int ROW_W     = SIMD_LANES * DATA_W
) (
  input  logic             clk,
  input  op_e              op,
  input  logic [BW-1:0]    batch,
  input  logic [DATA_W-1:0] imm,
  input  logic [ROW_W-1:0] a_row,
  input  logic [ROW_W-1:0] b_row,
  output logic [ROW_W-1:0] res_row
);
  for (genvar l = 0; l < SIMD_LANES; l++) begin : g_lane
    logic [DATA_W-1:0] a, b, lane_id;
    assign a       = a_row[l*DATA_W +: DATA_W];
    assign b       = b_row[l*DATA_W +: DATA_W];
    assign lane_id = DATA_W'(batch) * DATA_W'(SIMD_LANES) + DATA_W'(l);

    always_ff @(posedge clk) begin
      case (op)
        OP_ADD:  res_row[l*DATA_W +: DATA_W] <= a + b;
        OP_SUB:  res_row[l*DATA_W +: DATA_W] <= a - b;
        OP_AND:  res_row[l*DATA_W +: DATA_W] <= a & b;
        OP_OR:   res_row[l*DATA_W +: DATA_W] <= a | b;
        OP_MIN:  res_row[l*DATA_W +: DATA_W] <= ($signed(a) < $signed(b)) ? a : b;
        OP_MAX:  res_row[l*DATA_W +: DATA_W] <= ($signed(a) > $signed(b)) ? a : b;
        OP_SEED: res_row[l*DATA_W +: DATA_W] <= imm + lane_id;
        default: res_row[l*DATA_W +: DATA_W] <= a;
      endcase
    end
  end
endmodule

// File: rtl/wave_simd_unit.sv
module wave_simd_unit
  import wsu_pkg::*;
#(
  parameter int WAVE_LANES = 64,
  parameter int SIMD_LANES = 16,
  parameter int DATA_W     = 32,
  parameter int NUM_REGS   = 8,
  localparam int NBATCH    = WAVE_LANES / SIMD_LANES,
  localparam int BW        = (NBATCH > 1) ? $clog2(NBATCH) : 1,
  localparam int REG_AW    = $clog2(NUM_REGS),
  localparam int ROW_W     = SIMD_LANES * DATA_W,
  localparam int RF_AW     = REG_AW + BW
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_valid,
  input  logic [2:0]            in_op,
  input  logic [REG_AW-1:0]     in_dst,
  input  logic [REG_AW-1:0]     in_src_a,
  input  logic [REG_AW-1:0]     in_src_b,
  input  logic [DATA_W-1:0]     in_imm,
  input  logic [WAVE_LANES-1:0] in_exec,
  output logic [BW-1:0]         out_batch,
  output logic                  wr_valid,
  output logic [REG_AW-1:0]     wr_reg,
  output logic [SIMD_LANES-1:0] wr_lane_en,
  output logic [ROW_W-1:0]      wr_data,
  output logic                  st_valid,
  output logic [SIMD_LANES-1:0] st_lane_en,
  output logic [ROW_W-1:0]      st_data,
  output logic                  done,
  output logic                  err
);
  // stage 0: sequencer
  logic                  seq_vld, seq_last;
  logic [BW-1:0]         seq_batch;
  op_e                   seq_op;
  logic [REG_AW-1:0]     seq_dst, seq_src_a, seq_src_b;
  logic [DATA_W-1:0]     seq_imm;
  logic [SIMD_LANES-1:0] seq_mask;

  wsu_sequencer #(
    .WAVE_LANES(WAVE_LANES), .SIMD_LANES(SIMD_LANES),
    .REG_AW(REG_AW), .DATA_W(DATA_W)
  ) u_seq (
    .clk, .rst, .in_valid,
    .in_op(op_e'(in_op)), .in_dst, .in_src_a, .in_src_b, .in_imm, .in_exec,
    .seq_vld, .seq_batch, .seq_last, .seq_op, .seq_dst,
    .seq_src_a, .seq_src_b, .seq_imm, .seq_mask, .err_o(err)
  );

  // stage 1: register read
  logic                  s1_vld, s1_last;
  logic [BW-1:0]         s1_batch;
  op_e                   s1_op;
  logic [REG_AW-1:0]     s1_dst;
  logic [DATA_W-1:0]     s1_imm;
  logic [SIMD_LANES-1:0] s1_mask;
  logic [ROW_W-1:0]      rd_a, rd_b;

  // stage 2: lane ALU
  logic                  s2_vld, s2_last;
  logic [BW-1:0]         s2_batch;
  op_e                   s2_op;
  logic [REG_AW-1:0]     s2_dst;
  logic [SIMD_LANES-1:0] s2_mask;
  logic [ROW_W-1:0]      s2_res;
  logic [SIMD_LANES-1:0] rf_we;
  logic                  s2_alu, s2_store;

  assign s2_alu   = s2_vld && (s2_op != OP_STORE);
  assign s2_store = s2_vld && (s2_op == OP_STORE);
  assign rf_we    = s2_alu ? s2_mask : '0;

  wsu_regfile #(
    .ADDR_W(RF_AW), .SIMD_LANES(SIMD_LANES), .DATA_W(DATA_W)
  ) u_rf (
    .clk,
    .we(rf_we), .waddr({s2_dst, s2_batch}), .wdata(s2_res),
    .raddr_a({seq_src_a, seq_batch}), .raddr_b({seq_src_b, seq_batch}),
    .rdata_a(rd_a), .rdata_b(rd_b)
  );

  wsu_lane_alu #(
    .SIMD_LANES(SIMD_LANES), .DATA_W(DATA_W), .BW(BW)
  ) u_alu (
    .clk, .op(s1_op), .batch(s1_batch), .imm(s1_imm),
    .a_row(rd_a), .b_row(rd_b), .res_row(s2_res)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_vld <= 1'b0;
      s2_vld <= 1'b0;
    end else begin
      s1_vld <= seq_vld;
      s2_vld <= s1_vld;
    end
  end

  always_ff @(posedge clk) begin
    s1_last  <= seq_last;
    s1_batch <= seq_batch;
    s1_op    <= seq_op;
    s1_dst   <= seq_dst;
    s1_imm   <= seq_imm;
    s1_mask  <= seq_mask;
    s2_last  <= s1_last;
    s2_batch <= s1_batch;
    s2_op    <= s1_op;
    s2_dst   <= s1_dst;
    s2_mask  <= s1_mask;
  end

  // stage 3: writeback and registered outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      out_batch  <= '0;
      wr_valid   <= 1'b0;
      wr_reg     <= '0;
      wr_lane_en <= '0;
      wr_data    <= '0;
      st_valid   <= 1'b0;
      st_lane_en <= '0;
      st_data    <= '0;
      done       <= 1'b0;
    end else begin
      wr_valid   <= s2_alu && (|s2_mask);
      st_valid   <= s2_store && (|s2_mask);
      wr_lane_en <= s2_alu ? s2_mask : '0;
      st_lane_en <= s2_store ? s2_mask : '0;
      done       <= s2_vld && s2_last;
      if (s2_vld) begin
        out_batch <= s2_batch;
        wr_reg    <= s2_dst;
      end
      if (s2_alu)   wr_data <= s2_res;
      if (s2_store) st_data <= s2_res;
    end
  end

  // R8
  done_last_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (out_batch == BW'(NBATCH - 1)));

  // R6
  wr_nonempty_chk: assert property (@(posedge clk) disable iff (rst)
    wr_valid |-> (wr_lane_en != '0));

  // R7
  st_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    st_valid |-> (st_lane_en != '0 && !wr_valid && wr_lane_en == '0));
endmodule

// File: tb/wave_simd_unit_test.sv
`timescale 1ns/1ps
module wave_simd_unit_test;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [2:0]   in_op = '0;
  logic [2:0]   in_dst = '0, in_src_a = '0, in_src_b = '0;
  logic [31:0]  in_imm = '0;
  logic [63:0]  in_exec = '0;
  logic [1:0]   out_batch;
  logic         wr_valid, st_valid, done, err;
  logic [2:0]   wr_reg;
  logic [15:0]  wr_lane_en, st_lane_en;
  logic [511:0] wr_data, st_data;

  int checks = 0;
  int errors = 0;

  logic [31:0] model [8][64];
  logic [31:0] exp_v [2][64];
  int          slot_op [2], slot_dst [2], slot_sa [2], slot_sb [2];
  logic [31:0] slot_imm [2];
  logic [63:0] slot_mask [2];

  always #4 clk = ~clk;

  wave_simd_unit uut (
    .clk, .rst, .in_valid, .in_op, .in_dst, .in_src_a, .in_src_b, .in_imm, .in_exec,
    .out_batch, .wr_valid, .wr_reg, .wr_lane_en, .wr_data,
    .st_valid, .st_lane_en, .st_data, .done, .err
  );

  task automatic chk(bit ok, string what, logic [63:0] act, logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, expv);
    end
  endtask

  function automatic logic [31:0] calc(int op, logic [31:0] a, logic [31:0] b,
                                       logic [31:0] imm, int lane);
    case (op)
      0: return a + b;
      1: return a - b;
      2: return a & b;
      3: return a | b;
      4: return ($signed(a) < $signed(b)) ? a : b;
      5: return ($signed(a) > $signed(b)) ? a : b;
      6: return imm + 32'(lane);
      default: return a;
    endcase
  endfunction

  // expected results from the reference model, then commit masked lanes
  task automatic prep(int s, int op, int dst, int sa, int sb, logic [31:0] imm, logic [63:0] mask);
    slot_op[s] = op; slot_dst[s] = dst; slot_sa[s] = sa; slot_sb[s] = sb;
    slot_imm[s] = imm; slot_mask[s] = mask;
    for (int l = 0; l < 64; l++) exp_v[s][l] = calc(op, model[sa][l], model[sb][l], imm, l);
    if (op != 7)
      for (int l = 0; l < 64; l++) if (mask[l]) model[dst][l] = exp_v[s][l];
  endtask

  task automatic drive_slot(int s);
    in_valid = 1'b1; in_op = slot_op[s][2:0]; in_dst = slot_dst[s][2:0];
    in_src_a = slot_sa[s][2:0]; in_src_b = slot_sb[s][2:0];
    in_imm = slot_imm[s]; in_exec = slot_mask[s];
  endtask

  task automatic drive_stray(int dst, logic [31:0] imm);
    in_valid = 1'b1; in_op = 3'd6; in_dst = dst[2:0];
    in_src_a = '0; in_src_b = '0; in_imm = imm; in_exec = '1;
  endtask

  task automatic check_batch(int s, int k, string tag);
    logic [15:0] slice, en;
    logic [31:0] got, want;
    bit is_st, ewv, esv;
    int bad;
    slice = slot_mask[s][16*k +: 16];
    is_st = (slot_op[s] == 7);
    ewv = !is_st && (slice != 0);
    esv = is_st && (slice != 0);
    chk({wr_valid, st_valid, done} == {ewv, esv, k == 3},
        $sformatf("%s batch %0d valid/done flags (R2 R6 R8)", tag, k),
        64'({wr_valid, st_valid, done}), 64'({ewv, esv, k == 3}));
    if (ewv || esv) begin
      en = is_st ? st_lane_en : wr_lane_en;
      chk(en == slice && out_batch == 2'(k) && (is_st || wr_reg == 3'(slot_dst[s])),
          $sformatf("%s batch %0d lane enables/index (R5 R7)", tag, k),
          64'({out_batch, en}), 64'({2'(k), slice}));
      bad = 0; got = '0; want = '0;
      for (int l = 0; l < 16; l++) begin
        logic [31:0] d;
        d = is_st ? st_data[l*32 +: 32] : wr_data[l*32 +: 32];
        if (slice[l] && d != exp_v[s][16*k + l]) begin
          if (bad == 0) begin got = d; want = exp_v[s][16*k + l]; end
          bad++;
        end
      end
      chk(bad == 0, $sformatf("%s batch %0d lane data (R3 R4)", tag, k), 64'(got), 64'(want));
    end
  endtask

  // one instruction from slot 0; optional stray strobe one edge before the cadence point
  task automatic run_single(string tag, bit early, int sdst, logic [31:0] simm);
    @(negedge clk); drive_slot(0);
    @(negedge clk); in_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    if (early) drive_stray(sdst, simm);
    @(negedge clk); in_valid = 1'b0;
    check_batch(0, 0, tag);
    if (early) chk(err == 1'b1, {tag, " R10 early strobe flagged"}, 64'(err), 64'd1);
    for (int k = 1; k < 4; k++) begin
      @(negedge clk);
      check_batch(0, k, tag);
      if (early && k == 1) chk(err == 1'b0, {tag, " R10 err is one cycle"}, 64'(err), 64'd0);
    end
    @(negedge clk);
    chk(!wr_valid && !st_valid && !done, {tag, " R10 nothing after last batch"},
        64'({wr_valid, st_valid, done}), 64'd0);
  endtask

  // slot 0 then slot 1 on the 4-clock cadence, stray strobe landing with slot 0's done
  task automatic run_pair(string tag, int sdst, logic [31:0] simm);
    @(negedge clk); drive_slot(0);
    @(negedge clk); in_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    check_batch(0, 0, tag);
    chk(err == 1'b0, {tag, " R9 no err before cadence issue"}, 64'(err), 64'd0);
    drive_slot(1);
    @(negedge clk); in_valid = 1'b0;
    check_batch(0, 1, tag);
    chk(err == 1'b0, {tag, " R9 cadence issue accepted"}, 64'(err), 64'd0);
    @(negedge clk);
    check_batch(0, 2, tag);
    drive_stray(sdst, simm);
    @(negedge clk); in_valid = 1'b0;
    check_batch(0, 3, tag);
    chk(err == 1'b1, {tag, " R10 reject together with done"}, 64'(err), 64'd1);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check_batch(1, k, {tag, " second"});
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk(!wr_valid && !st_valid && !done && !err, "R1 reset outputs",
        64'({wr_valid, st_valid, done, err}), 64'd0);
    rst = 1'b0;

    // R3 seed values: imm plus lane index
    prep(0, 6, 1, 0, 0, 32'd100, '1);           run_single("R3 seed r1", 0, 0, 0);
    prep(0, 6, 2, 0, 0, 32'hFFFF_FFD8, '1);     run_single("R3 seed r2", 0, 0, 0);
    prep(0, 1, 0, 1, 1, 0, '1);                 run_single("R3 sub zero", 0, 0, 0);
    for (int r = 3; r < 8; r++) begin
      prep(0, 6, r, 0, 0, 32'(1000 * r), '1);   run_single("R4 seed init", 0, 0, 0);
    end

    // R5 R6 partial mask, batch 2 empty; masked lanes must keep their seed
    prep(0, 0, 3, 1, 2, 0, 64'h1234_0000_A5A5_FFFF); run_single("R5 masked add", 0, 0, 0);
    prep(0, 7, 0, 3, 0, 0, '1);                 run_single("R5 readback r3", 0, 0, 0);

    // R3 signed min/max and bitwise ops
    prep(0, 5, 4, 2, 0, 0, '1);                 run_single("R3 signed max", 0, 0, 0);
    prep(0, 4, 5, 2, 0, 0, '1);                 run_single("R3 signed min", 0, 0, 0);
    prep(0, 2, 6, 1, 2, 0, '1);                 run_single("R3 and", 0, 0, 0);
    prep(0, 3, 7, 1, 2, 0, '1);                 run_single("R3 or", 0, 0, 0);

    // R6 R8 all-zero mask: no writes, done still pulses
    prep(0, 0, 1, 1, 1, 0, '0);                 run_single("R6 empty mask", 0, 0, 0);
    prep(0, 7, 0, 1, 0, 0, '1);                 run_single("R6 r1 unchanged", 0, 0, 0);

    // R9 dependent back-to-back pair, R10 stray strobe coinciding with done
    prep(0, 0, 6, 3, 1, 0, '1);
    prep(1, 1, 7, 6, 2, 0, '1);
    run_pair("R9 pair", 5, 32'd999);
    prep(0, 7, 0, 7, 0, 0, '1);                 run_single("R9 readback r7", 0, 0, 0);
    prep(0, 7, 0, 5, 0, 0, '1);                 run_single("R10 r5 untouched", 0, 0, 0);

    // R10 strobe one edge before the cadence point
    prep(0, 3, 3, 0, 1, 0, '1);                 run_single("R10 early", 1, 4, 32'd777);
    prep(0, 7, 0, 4, 0, 0, '1);                 run_single("R10 r4 untouched", 0, 0, 0);

    // R7 store with a partial mask and one empty batch
    prep(0, 7, 0, 3, 0, 0, 64'hFFFF_0000_0001_8000); run_single("R7 partial store", 0, 0, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule